// File: doc/BRIEF.md
# DAC Gain and Offset Correction Unit

This block sits in front of a four-channel 16-bit digital-to-analog converter and turns the code a user asks for into the code that should actually be sent, after removing that channel's calibrated gain error and zero error. A calibration store keeps a gain factor and an offset factor for every channel. It keeps one complete set for each output range. A range input selects both the factor set and the scaling of the gain term.

Factors are signed 16-bit numbers in quarter-LSB units. In unipolar mode (range = 1) the corrected value is V·(1 − G/2^18) − O/4, with V read as straight binary. In bipolar mode (range = 0) it is V·(1 − G/2^17) − O/4, with V read as two's complement. The arithmetic is exact scaled-integer arithmetic with 18 fractional bits. The result is rounded once and then saturated to the code range of the active coding. Requests are accepted every cycle, and each request returns after a fixed latency.

Top module: `dacc_corrector`

## Requirements
- R1: With in_range = 1, in_value is read as unsigned (0x0000 zero, 0x8000 midscale, 0xFFFF full scale), and out_code equals round(V − V·G/262144 − O/4), using the gain and offset stored for that channel in set 1.
- R2: With in_range = 0, in_value is read as two's complement (0x8000 most negative, 0x0000 midscale, 0x7FFF most positive), and out_code equals round(V − V·G/131072 − O/4), using the factors stored for that channel in set 0.
- R3: Rounding goes to the nearest integer, and an exact half goes away from zero (for example, 100.5 gives 101 and −5.5 gives −6).
- R4: A result below the lowest legal code is replaced by that code, and a result above the highest legal code is replaced by that code. The limits are 0x0000 and 0xFFFF when in_range = 1, and 0x8000 and 0x7FFF when in_range = 0.
- R5: Factors are written when cal_we = 1. The write goes to set cal_set, channel cal_ch, and to the gain factor when cal_kind = 0 or the offset factor when cal_kind = 1. Each of the 2×4×2 entries is independent, and a correction uses only the entry pair addressed by its own in_range and in_ch.
- R6: out_valid rises exactly two clock edges after the edge that samples in_valid = 1. A new request may be presented on every cycle, and results come out in order with no gaps added.
- R7: While out_valid = 0, out_code keeps the value of the last result.
- R8: A synchronous active-high rst clears out_valid and out_code to 0.
- R9: A factor written on the same edge that samples a request is not used by that request. It is used only by requests sampled on later edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_we | input | 1 | Calibration write strobe |
| cal_set | input | 1 | Factor set to write (1 unipolar, 0 bipolar) |
| cal_ch | input | 2 | Channel to write |
| cal_kind | input | 1 | 0 gain factor, 1 offset factor |
| cal_wdata | input | 16 | Signed factor value |
| in_valid | input | 1 | Request strobe |
| in_ch | input | 2 | Channel of the request |
| in_range | input | 1 | 1 unipolar straight binary, 0 bipolar two's complement |
| in_value | input | 16 | Desired code |
| out_valid | output | 1 | Result strobe |
| out_code | output | 16 | Corrected, rounded and clamped code |

## Verification
The hardest cases to reach are the exact rounding ties. A tie happens only when the gain product and the quarter-LSB offset together leave a fraction of exactly one half. The stimulus creates this by programming one channel with a zero gain and an offset of ±2 quarter-LSBs, then sweeping values of both signs in both codings. Saturation is reached by pairing full-scale codes with the most extreme gain and offset factors. The same-edge write case is reached by issuing a factor write and a request on the same cycle.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic {
    RANGE_BIPOLAR  = 1'b0,
    RANGE_UNIPOLAR = 1'b1
  } range_e;

  typedef enum logic {
    FACT_GAIN   = 1'b0,
    FACT_OFFSET = 1'b1
  } fact_e;

  localparam int unsigned NUM_KINDS = 2;
endpackage

// File: rtl/dacc_cal_store.sv
module dacc_cal_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CH_N   = 4,
  localparam int unsigned CH_W   = $clog2(CH_N),
  localparam int unsigned ADDR_W = CH_W + 1,
  localparam int unsigned DEPTH  = 2 * CH_N
) (
  input  logic              clk,
  input  logic              we,
  input  logic              wkind,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rgain,
  output logic [DATA_W-1:0] roff
);
  import dacc_pkg::*;

  logic [DATA_W-1:0] rd_q [NUM_KINDS];

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (wkind == 1'(k))) mem[waddr] <= wdata;
      rd_q[k] <= mem[raddr];
    end
  end

  assign rgain = rd_q[FACT_GAIN];
  assign roff  = rd_q[FACT_OFFSET];
endmodule

// File: rtl/dacc_arith.sv
module dacc_arith #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC   = 18,
  localparam int unsigned ACC_W = DATA_W + FRAC + 4,
  localparam int unsigned PRD_W = 2 * DATA_W + 1
) (
  input  logic              range_uni,
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] gain,
  input  logic [DATA_W-1:0] offs,
  output logic [DATA_W-1:0] code
);
  localparam logic [ACC_W-1:0] HALF = {{(ACC_W-1){1'b0}}, 1'b1} << (FRAC - 1);

  logic signed [DATA_W:0]   v_s;
  logic signed [PRD_W-1:0]  prod;
  logic signed [ACC_W-1:0]  t_base, t_gain, t_off, sum, rnd, hi, lo, clamped;
  logic        [ACC_W-1:0]  mag, q;
  logic                     neg;
  logic                     unused_hi;

  always_comb begin
    v_s    = range_uni ? {1'b0, value} : {value[DATA_W-1], value};
    prod   = v_s * $signed(gain);
    t_base = {{(ACC_W-DATA_W-1){v_s[DATA_W]}}, v_s} <<< FRAC;
    t_gain = {{(ACC_W-PRD_W){prod[PRD_W-1]}}, prod};
    if (!range_uni) t_gain = t_gain <<< 1;
    t_off  = {{(ACC_W-DATA_W){offs[DATA_W-1]}}, offs} <<< (FRAC - 2);
    sum    = t_base - t_gain - t_off;
    neg    = sum[ACC_W-1];
    mag    = neg ? -sum : sum;
    q      = (mag + HALF) >> FRAC;
    rnd    = neg ? -$signed(q) : $signed(q);
    if (range_uni) begin
      hi = {{(ACC_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};
      lo = '0;
    end else begin
      hi = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
      lo = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    end
    if (rnd > hi)      clamped = hi;
    else if (rnd < lo) clamped = lo;
    else               clamped = rnd;
    code = clamped[DATA_W-1:0];
  end

  assign unused_hi = ^clamped[ACC_W-1:DATA_W];
endmodule

// File: rtl/dacc_corrector.sv
module dacc_corrector #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CH_N   = 4,
  parameter int unsigned FRAC   = 18,
  localparam int unsigned CH_W  = $clog2(CH_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_we,
  input  logic              cal_set,
  input  logic [CH_W-1:0]   cal_ch,
  input  logic              cal_kind,
  input  logic [DATA_W-1:0] cal_wdata,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_ch,
  input  logic              in_range,
  input  logic [DATA_W-1:0] in_value,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_code
);
  logic              s1_valid;
  logic              s1_range;
  logic [DATA_W-1:0] s1_val;
  logic [DATA_W-1:0] s1_gain;
  logic [DATA_W-1:0] s1_off;
  logic [DATA_W-1:0] corr;

  dacc_cal_store #(.DATA_W(DATA_W), .CH_N(CH_N)) store_i (
    .clk   (clk),
    .we    (cal_we),
    .wkind (cal_kind),
    .waddr ({cal_set, cal_ch}),
    .wdata (cal_wdata),
    .raddr ({in_range, in_ch}),
    .rgain (s1_gain),
    .roff  (s1_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_range <= 1'b0;
      s1_val   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_range <= in_range;
        s1_val   <= in_value;
      end
    end
  end

  dacc_arith #(.DATA_W(DATA_W), .FRAC(FRAC)) arith_i (
    .range_uni (s1_range),
    .value     (s1_val),
    .gain      (s1_gain),
    .offs      (s1_off),
    .code      (corr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_code <= corr;
    end
  end
endmodule

// File: rtl/dacc_corrector_chk.sv
module dacc_corrector_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_code,
  input logic              s1_valid,
  input logic [DATA_W-1:0] s1_val,
  input logic [DATA_W-1:0] s1_gain,
  input logic [DATA_W-1:0] s1_off
);
  logic [1:0] live;

  always_ff @(posedge clk) begin
    if (rst)            live <= 2'd0;
    else if (live != 2'd2) live <= live + 2'd1;
  end

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (live == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (live != 2'd0 && !out_valid) |-> $stable(out_code));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_code == '0));

  // R1 R2
  identity_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_gain == '0 && s1_off == '0) |=> (out_code == $past(s1_val)));
endmodule

bind dacc_corrector dacc_corrector_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_code  (out_code),
  .s1_valid  (s1_valid),
  .s1_val    (s1_val),
  .s1_gain   (s1_gain),
  .s1_off    (s1_off)
);

// File: tb/dacc_corrector_tb_top.sv
`timescale 1ns/1ps
module dacc_corrector_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cal_we = 1'b0, cal_set = 1'b0, cal_kind = 1'b0;
  logic [1:0]  cal_ch = '0;
  logic [15:0] cal_wdata = '0;
  logic        in_valid = 1'b0, in_range = 1'b0;
  logic [1:0]  in_ch = '0;
  logic [15:0] in_value = '0;
  logic        out_valid;
  logic [15:0] out_code;

  int    n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;
  bit    seen_edge = 1'b0;

  int sh_g [2][4];
  int sh_o [2][4];

  bit    m1_v = 0, mo_v = 0;
  int    m1_c = 0, mo_c = 0;
  string m1_t = "R7", mo_t = "R7";

  always #2.5 clk = ~clk;

  dacc_corrector dut_i (
    .clk(clk), .rst(rst), .cal_we(cal_we), .cal_set(cal_set), .cal_ch(cal_ch),
    .cal_kind(cal_kind), .cal_wdata(cal_wdata), .in_valid(in_valid), .in_ch(in_ch),
    .in_range(in_range), .in_value(in_value), .out_valid(out_valid), .out_code(out_code)
  );

  function automatic int ref_code(bit uni, int val, int g, int o);
    longint v, num, mag, q, r, hi, lo;
    v   = uni ? longint'(val) : (val >= 32768 ? longint'(val) - 65536 : longint'(val));
    num = v * 262144 - v * g * (uni ? 1 : 2) - longint'(o) * 65536;
    mag = (num < 0) ? -num : num;
    q   = (mag + 131072) / 262144;
    r   = (num < 0) ? -q : q;
    hi  = uni ? 65535 : 32767;
    lo  = uni ? 0 : -32768;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return int'(r) & 32'hFFFF;
  endfunction

  always @(posedge clk) begin
    seen_edge = 1'b1;
    if (rst) begin
      m1_v = 0; mo_v = 0; mo_c = 0; mo_t = "R8";
    end else begin
      if (m1_v) begin mo_c = m1_c; mo_t = m1_t; end
      else mo_t = "R7";
      mo_v = m1_v;
      m1_v = in_valid;
      if (in_valid) begin
        m1_c = ref_code(in_range, int'(in_value), sh_g[in_range][in_ch], sh_o[in_range][in_ch]);
        m1_t = cur_tag;
      end
    end
    if (cal_we) begin
      if (cal_kind) sh_o[cal_set][cal_ch] = int'($signed(cal_wdata));
      else          sh_g[cal_set][cal_ch] = int'($signed(cal_wdata));
    end
  end

  always @(negedge clk) begin
    if (seen_edge && !done) begin
      if (rst) begin
        n_cmp++;
        if (out_valid !== 1'b0 || out_code !== 16'h0) begin
          n_bad++;
          $display("FAIL R8 reset: valid=%0b code=%h expected valid=0 code=0000", out_valid, out_code);
        end
      end else begin
        n_cmp++;
        if (out_valid !== mo_v) begin
          n_bad++;
          $display("FAIL R6 out_valid=%0b expected %0b", out_valid, mo_v);
        end
        n_cmp++;
        if (out_code !== 16'(mo_c)) begin
          n_bad++;
          $display("FAIL %s out_code=%h expected %h", mo_t, out_code, 16'(mo_c));
        end
      end
    end
  end

  task automatic cal_wr(bit s, int ch, bit kind, int val);
    cal_we = 1; cal_set = s; cal_ch = 2'(ch); cal_kind = kind; cal_wdata = 16'(val);
    @(negedge clk);
    cal_we = 0;
  endtask

  task automatic send(bit uni, int ch, int val);
    in_valid = 1; in_range = uni; in_ch = 2'(ch); in_value = 16'(val);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 4; c++) begin sh_g[s][c] = 0; sh_o[s][c] = 0; end
    idle(3);
    // R5: program every entry of both sets (write port usable during reset too)
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 4; c++) begin
        cal_wr(s[0], c, 1'b0, (s ? 1 : -1) * (c + 1) * 1700 + 37);
        cal_wr(s[0], c, 1'b1, (s ? -1 : 1) * (c * 211 - 150));
      end
    rst = 0;
    idle(3);

    cur_tag = "R1";
    foreach (sh_g[, c]) begin
      send(1'b1, c, 16'h0000); send(1'b1, c, 16'h8000);
      send(1'b1, c, 16'h1234); send(1'b1, c, 16'hFF00);
    end
    idle(4);

    cur_tag = "R2";
    for (int c = 0; c < 4; c++) begin
      send(1'b0, c, 16'h0000); send(1'b0, c, 16'h7000);
      send(1'b0, c, 16'h9000); send(1'b0, c, 16'hFFFF);
    end
    idle(4);

    cur_tag = "R5";
    for (int c = 0; c < 4; c++) begin send(1'b1, c, 16'h4000); send(1'b0, c, 16'h4000); end
    idle(4);

    // R3 ties: zero gain, offset of +-2 quarter LSB leaves exactly one half
    cur_tag = "R3";
    cal_wr(1'b1, 3, 1'b0, 0); cal_wr(1'b1, 3, 1'b1, -2);
    cal_wr(1'b0, 3, 1'b0, 0); cal_wr(1'b0, 3, 1'b1, 2);
    cal_wr(1'b0, 2, 1'b0, 0); cal_wr(1'b0, 2, 1'b1, -2);
    idle(1);
    send(1'b1, 3, 100); send(1'b1, 3, 0); send(1'b1, 3, 65534);
    send(1'b0, 3, 16'hFFFB); send(1'b0, 3, 5); send(1'b0, 3, 0);
    send(1'b0, 2, 16'hFFFB); send(1'b0, 2, 7); send(1'b0, 2, 16'hFFFF);
    idle(4);

    // R4 saturation at both ends of both codings
    cur_tag = "R4";
    cal_wr(1'b1, 1, 1'b0, 0);      cal_wr(1'b1, 1, 1'b1, -400);
    cal_wr(1'b1, 2, 1'b0, 0);      cal_wr(1'b1, 2, 1'b1, 400);
    cal_wr(1'b0, 1, 1'b0, -32768); cal_wr(1'b0, 1, 1'b1, 0);
    cal_wr(1'b1, 0, 1'b0, -32768); cal_wr(1'b1, 0, 1'b1, -32768);
    idle(1);
    send(1'b1, 1, 16'hFFFF); send(1'b1, 1, 16'hFFE0);
    send(1'b1, 2, 16'h0000); send(1'b1, 2, 16'h0050);
    send(1'b0, 1, 16'h7FFF); send(1'b0, 1, 16'h8000); send(1'b0, 1, 16'h0100);
    send(1'b1, 0, 16'hF000); send(1'b1, 0, 16'h0001);
    idle(4);

    // R9 write and request on the same edge
    cur_tag = "R9";
    in_valid = 1; in_range = 1; in_ch = 2'd1; in_value = 16'h2000;
    cal_we = 1; cal_set = 1; cal_ch = 2'd1; cal_kind = 1; cal_wdata = 16'd3000;
    @(negedge clk);
    cal_we = 0;
    in_value = 16'h2000;
    @(negedge clk);
    in_valid = 0;
    idle(4);

    // R6 R7: random stream with gaps, factor rewrites in between
    cur_tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0)
        cal_wr(1'($urandom_range(0, 1)), $urandom_range(0, 3), 1'($urandom_range(0, 1)),
               int'($urandom_range(0, 65535)) - 32768);
      if ($urandom_range(0, 3) != 0)
        send(1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 65535));
      else
        idle($urandom_range(1, 3));
    end
    idle(4);

    // R8 reset in mid-stream
    cur_tag = "R8";
    send(1'b1, 0, 16'h1111);
    rst = 1;
    idle(3);
    rst = 0;
    idle(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule